// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Core

This core keeps wall-clock time and calendar date for a chip that receives a 32,768 Hz tick as a one-cycle enable pulse on its system clock. A prescaler counts tick pulses and produces one seconds step per full count. The step then ripples through a carry chain of seconds, minutes, hours, date, month and year, all held as packed BCD. A day-of-week counter follows each date step. A century flag flips each time the year goes from 99 to 00.

A host sets the time through a single-cycle write port and observes it through a combinational read port. Both ports address eight byte registers. Any write to a time register also clears the prescaler, so the first step after setting the time comes one full second later. Month lengths and February in leap years are handled in BCD without converting to binary. A field that holds a value outside its range returns to its minimum on its next step.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the registers read, from address 0 to 7: 00, 00, 00, 01, 01, 01, 00, 00 (hex).
- R2: The seconds register advances once for every PRESCALE cycles in which tick_i is high. Cycles with tick_i low do not count and do not advance anything.
- R3: The register map is seconds (addr 0, bits 6:0), minutes (1, bits 6:0), hours (2, bits 5:0, with the century flag in bit 6), day-of-week (3, bits 2:0), date (4, bits 5:0), month (5, bits 4:0), year (6, bits 7:0) and control (7, bits 7:0). Bits outside these fields are dropped on write and read as 0.
- R4: Seconds and minutes step from 59 to 00 and carry. Hours step from 23 to 00 and carry into the date.
- R5: Day-of-week advances on every date step and goes from 7 back to 1.
- R6: The date steps from the month's last day to 01 and carries into the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 28 or 29 days. All other months have 31.
- R7: February has 29 days when the BCD year value is divisible by 4, including year 00.
- R8: The month steps from 12 to 01 and carries into the year. The year steps from 99 to 00 and toggles the century flag (hours register, bit 6).
- R9: A write to addresses 0 to 6 loads the value and restarts the prescaler, so the next step needs a further PRESCALE ticks. A write to address 7 does not disturb the prescaler.
- R10: A field holding a value that is out of range (at or above its top value, or with a low BCD digit above 9) goes to its minimum on its next step and carries into the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 32,768 Hz |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |

## Verification
The bench targets the midnight of 31 December 99. There the whole chain carries at once, and the century flag must flip. A design with a broken carry link would leave one field stale. Around February the bench drives years 23, 24 and 00. A wrong leap test would skip 29 February or invent it. The bench also writes out-of-range minutes and seconds, and it writes a time register part way through a second. A design that saturates or stalls on bad BCD would freeze, and one that ignores the restart would step early. A write to the control register must not delay the step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned AW        = 3;
  localparam int unsigned DW        = 8;
  localparam int unsigned NUM_CHAIN = 6;
  localparam int unsigned IDX_HOUR  = 2;
  localparam int unsigned IDX_DATE  = 3;
  localparam int unsigned IDX_MON   = 4;
  localparam int unsigned IDX_YEAR  = 5;

  typedef enum logic [AW-1:0] {
    A_SEC  = 3'd0,
    A_MIN  = 3'd1,
    A_HOUR = 3'd2,
    A_DAY  = 3'd3,
    A_DATE = 3'd4,
    A_MON  = 3'd5,
    A_YEAR = 3'd6,
    A_CTRL = 3'd7
  } reg_addr_e;

  // carry chain order: sec, min, hour, date, month, year
  localparam logic [DW-1:0] CHAIN_MASK  [NUM_CHAIN] = '{8'h7f, 8'h7f, 8'h3f, 8'h3f, 8'h1f, 8'hff};
  localparam logic [DW-1:0] CHAIN_FIRST [NUM_CHAIN] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
  localparam logic [DW-1:0] CHAIN_LAST  [NUM_CHAIN] = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99};
  localparam logic [AW-1:0] CHAIN_ADDR  [NUM_CHAIN] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};

  localparam logic [2:0] DAY_FIRST = 3'd1;
  localparam logic [2:0] DAY_LAST  = 3'd7;

  function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // 10 mod 4 == 2, so only the tens parity and low units bits matter
  function automatic logic bcd_is_leap(input logic [DW-1:0] y);
    logic [1:0] r;
    r = y[1:0] + {y[4], 1'b0};
    return r == 2'b00;
  endfunction

  function automatic logic [DW-1:0] bcd_month_last(input logic [DW-1:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic sec_stb_o
);
  localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == CNT_LAST);
  assign sec_stb_o = tick_i && !restart_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field import rtc_pkg::*; #(
  parameter logic [DW-1:0] MASK  = 8'hff,
  parameter logic [DW-1:0] FIRST = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          inc_i,
  input  logic [DW-1:0] last_i,
  output logic [DW-1:0] val_o,
  output logic          wrap_o
);
  // at top value or malformed BCD: next step wraps and carries
  assign wrap_o = (val_o >= last_i) || (val_o[3:0] > 4'd9);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= FIRST;
    else if (wr_i)  val_o <= wr_data_i & MASK;
    else if (inc_i) val_o <= wrap_o ? FIRST : bcd_inc(val_o);
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core import rtc_pkg::*; #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic                 time_wr;
  logic                 sec_stb;
  logic [DW-1:0]        field_q [NUM_CHAIN];
  logic [NUM_CHAIN-1:0] inc;
  logic [NUM_CHAIN-1:0] wrap;
  logic [DW-1:0]        date_last;
  logic [2:0]           day_q;
  logic                 cent_q;
  logic [DW-1:0]        ctrl_q;

  assign time_wr = wr_en_i && (wr_addr_i != A_CTRL);

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .restart_i(time_wr),
    .sec_stb_o(sec_stb)
  );

  assign date_last = bcd_month_last(field_q[IDX_MON], bcd_is_leap(field_q[IDX_YEAR]));

  for (genvar i = 0; i < NUM_CHAIN; i++) begin : g_chain
    logic [DW-1:0] last;
    if (i == IDX_DATE) begin : g_dyn
      assign last = date_last;
    end else begin : g_fix
      assign last = CHAIN_LAST[i];
    end
    if (i == 0) begin : g_head
      assign inc[i] = sec_stb;
    end else begin : g_link
      assign inc[i] = inc[i-1] & wrap[i-1];
    end
    rtc_bcd_field #(.MASK(CHAIN_MASK[i]), .FIRST(CHAIN_FIRST[i])) u_field (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (time_wr && (wr_addr_i == CHAIN_ADDR[i])),
      .wr_data_i(wr_data_i),
      .inc_i    (inc[i]),
      .last_i   (last),
      .val_o    (field_q[i]),
      .wrap_o   (wrap[i])
    );
  end

  // day-of-week follows every date step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             day_q <= DAY_FIRST;
    else if (wr_en_i && wr_addr_i == A_DAY)  day_q <= wr_data_i[2:0];
    else if (inc[IDX_DATE])                  day_q <= (day_q >= DAY_LAST) ? DAY_FIRST : day_q + 3'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cent_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == A_HOUR)   cent_q <= wr_data_i[6];
    else if (inc[IDX_YEAR] && wrap[IDX_YEAR])  cent_q <= ~cent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == A_CTRL) ctrl_q <= wr_data_i;
  end

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = field_q[0];
      A_MIN:   rd_data_o = field_q[1];
      A_HOUR:  rd_data_o = {1'b0, cent_q, field_q[IDX_HOUR][5:0]};
      A_DAY:   rd_data_o = {5'd0, day_q};
      A_DATE:  rd_data_o = field_q[IDX_DATE];
      A_MON:   rd_data_o = field_q[IDX_MON];
      A_YEAR:  rd_data_o = field_q[IDX_YEAR];
      default: rd_data_o = ctrl_q;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [2:0] rd_addr_i,
  input logic [7:0] rd_data_o,
  input logic       sec_stb,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] date_q,
  input logic [7:0] year_q,
  input logic       cent_q
);
  // R2
  stb_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb |-> tick_i);

  // R9
  write_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != 3'd7) |=> !sec_stb);

  // R4
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_stb && !(wr_en_i && wr_addr_i == 3'd0)) |=> $stable(sec_q));

  // R3
  sec_msb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 3'd0) |-> !rd_data_o[7]);

  // R6
  date_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_stb && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23)
    |=> (date_q != 8'h00 && date_q <= 8'h31));

  // R8
  century_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cent_q) |-> ($past(wr_en_i && wr_addr_i == 3'd2) ||
                          (year_q == 8'h00 && $past(year_q) == 8'h99)));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .sec_stb  (sec_stb),
  .sec_q    (field_q[0]),
  .min_q    (field_q[1]),
  .hour_q   (field_q[2]),
  .date_q   (field_q[3]),
  .year_q   (field_q[5]),
  .cent_q   (cent_q)
);

// File: tb/tb_rtc_bcd_core.sv
`timescale 1ns/1ps
module tb_rtc_bcd_core;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [7:0] m [8];
  bit         m_cent;
  int         pc;
  logic [7:0] view [8];

  always #5 clk = ~clk;

  rtc_bcd_core #(.PRESCALE(PRE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic int b2i(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic bit adv(inout logic [7:0] v, input int lo, input int hi);
    if (v[3:0] > 4'd9 || b2i(v) >= hi) begin
      v = i2b(lo);
      return 1'b1;
    end
    v = i2b(b2i(v) + 1);
    return 1'b0;
  endfunction

  function automatic int mdays(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expv(int a);
    if (a == 2) return {1'b0, m_cent, m[2][5:0]};
    return m[a];
  endfunction

  task automatic model_second();
    bit c;
    c = adv(m[0], 0, 59);
    if (c) c = adv(m[1], 0, 59);
    if (c) c = adv(m[2], 0, 23);
    if (c) begin
      m[3] = (m[3] >= 8'd7) ? 8'd1 : m[3] + 8'd1;
      c = adv(m[4], 1, mdays(b2i(m[5]), b2i(m[6])));
      if (c) c = adv(m[5], 1, 12);
      if (c) c = adv(m[6], 0, 99);
      if (c) m_cent = ~m_cent;
    end
  endtask

  // behavioural reference, advanced on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
      m_cent = 1'b0;
      pc = 0;
    end else if (wr_en && wr_addr != 3'd7) begin
      case (wr_addr)
        3'd0: m[0] = wr_data & 8'h7f;
        3'd1: m[1] = wr_data & 8'h7f;
        3'd2: begin m[2] = wr_data & 8'h3f; m_cent = wr_data[6]; end
        3'd3: m[3] = wr_data & 8'h07;
        3'd4: m[4] = wr_data & 8'h3f;
        3'd5: m[5] = wr_data & 8'h1f;
        default: m[6] = wr_data;
      endcase
      pc = 0;
    end else begin
      if (wr_en) m[7] = wr_data;
      if (tick) begin
        pc++;
        if (pc == PRE) begin
          pc = 0;
          model_second();
        end
      end
    end
  end

  // full register compare every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int a = 0; a < 8; a++) begin
        rd_addr = 3'(a);
        #0.1;
        view[a] = rd_data;
        checks++;
        if (rd_data !== expv(a)) begin
          failures++;
          $display("FAIL %s model compare reg%0d actual=%h expected=%h", cur_req, a, rd_data, expv(a));
        end
      end
    end
  end

  task automatic step(bit tk, bit we, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    tick = tk; wr_en = we; wr_addr = a; wr_data = d;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic settle();
    step(1'b0, 1'b0, 3'd0, 8'h00);
    #2;
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dy,
                          logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
    wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dy);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y);
  endtask

  task automatic expect_reg(string req, int a, logic [7:0] e);
    checks++;
    if (view[a] !== e) begin
      failures++;
      $display("FAIL %s reg%0d actual=%h expected=%h", req, a, view[a], e);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset values
    cur_req = "R1";
    expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00); expect_reg("R1", 2, 8'h00);
    expect_reg("R1", 3, 8'h01); expect_reg("R1", 4, 8'h01); expect_reg("R1", 5, 8'h01);
    expect_reg("R1", 6, 8'h00); expect_reg("R1", 7, 8'h00);

    // R3 field masks and century bit
    cur_req = "R3";
    wr(3'd7, 8'hA5); wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    settle();
    expect_reg("R3", 7, 8'hA5); expect_reg("R3", 0, 8'h7F);
    expect_reg("R3", 2, 8'h7F); expect_reg("R3", 3, 8'h07);

    // R10 out-of-range seconds and minutes wrap with carry
    cur_req = "R10";
    wr(3'd2, 8'h05); wr(3'd1, 8'h5C);
    tick_n(PRE); settle();
    expect_reg("R10", 0, 8'h00); expect_reg("R10", 1, 8'h00); expect_reg("R10", 2, 8'h06);

    // R9 time write restarts prescaler, control write does not
    cur_req = "R9";
    tick_n(2); wr(3'd1, 8'h30); tick_n(PRE - 1); settle();
    expect_reg("R9", 0, 8'h00);
    tick_n(1); settle();
    expect_reg("R9", 0, 8'h01);
    tick_n(2); wr(3'd7, 8'h3C); tick_n(PRE - 2); settle();
    expect_reg("R9", 0, 8'h02); expect_reg("R9", 7, 8'h3C);

    // R2 no advance without ticks
    cur_req = "R2";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 3'd0, 8'h00);
    settle();
    expect_reg("R2", 0, 8'h02);

    // R4 and R5 midnight rollover
    cur_req = "R4";
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h21);
    tick_n(PRE); settle();
    expect_reg("R4", 0, 8'h59);
    tick_n(PRE); settle();
    expect_reg("R4", 0, 8'h00); expect_reg("R4", 1, 8'h00); expect_reg("R4", 2, 8'h00);
    expect_reg("R5", 3, 8'h01); expect_reg("R6", 4, 8'h16);

    // R6 month lengths
    cur_req = "R6";
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21);
    tick_n(PRE); settle();
    expect_reg("R6", 4, 8'h01); expect_reg("R6", 5, 8'h05); expect_reg("R5", 3, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 8'h21);
    tick_n(PRE); settle();
    expect_reg("R6", 4, 8'h01); expect_reg("R6", 5, 8'h02);

    // R7 leap years
    cur_req = "R7";
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick_n(PRE); settle();
    expect_reg("R7", 4, 8'h01); expect_reg("R7", 5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick_n(PRE); settle();
    expect_reg("R7", 4, 8'h29); expect_reg("R7", 5, 8'h02);
    wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23);
    tick_n(PRE); settle();
    expect_reg("R7", 4, 8'h01); expect_reg("R7", 5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    tick_n(PRE); settle();
    expect_reg("R7", 4, 8'h29);

    // R8 year and century rollover
    cur_req = "R8";
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
    tick_n(PRE); settle();
    expect_reg("R8", 2, 8'h40); expect_reg("R8", 6, 8'h00);
    expect_reg("R8", 5, 8'h01); expect_reg("R8", 4, 8'h01);
    set_time(8'h59, 8'h59, 8'h63, 8'h03, 8'h31, 8'h12, 8'h99);
    tick_n(PRE); settle();
    expect_reg("R8", 2, 8'h00); expect_reg("R8", 6, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule